// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block is the first stage of a receiver for a byte-oriented Reed-Solomon code with 255 symbols per word, 16 of them parity. The received word streams in one 8-bit symbol per clock, starting with the coefficient of the highest power. A start strobe, active low, marks the first symbol of each word. The next 254 cycles carry the remaining symbols, with no idle cycles inside a word.

Sixteen accumulators work in parallel. Each one evaluates the received polynomial at one root of the generator polynomial by Horner's rule, using a multiplier by a fixed field constant and an XOR. The cycle after the final symbol, the block shows all sixteen results and pulses a completion strobe for one cycle. During that cycle an error indicator is raised if any result is nonzero. A word with all results zero is a valid codeword. The results stay on the output until the next word begins. A new word may start in the completion cycle itself, so words can follow one another with no gap. Solving the key equation and correcting errors are left to later stages.

Top module: `rs_syndrome`

## Requirements
- R1: The first symbol after the start strobe (`start_n` low) is the coefficient of x^254 and the last is the coefficient of x^0. A word with only its first symbol equal to 1 gives syndrome j = alpha^(254*j). A word with only its last symbol equal to v gives v in every syndrome.
- R2: Syndrome j (j = 0..15), on bits [8j+7:8j] of `synd_o`, equals r(alpha^j). Here r is the received polynomial over GF(2^8) with field polynomial 0x11D, and alpha = 0x02.
- R3: `done_o` is high for exactly one cycle. That is the cycle after the 255th symbol, which is 255 clock edges after the start cycle. It is low at all other times.
- R4: `err_o` is high only while `done_o` is high, and then only when at least one syndrome is nonzero. A valid codeword gives all syndromes zero and `err_o` low. A corrupted word gives `err_o` high.
- R5: Outside a word, while `start_n` is high, the symbol input has no effect: `synd_o` holds its value and `done_o` stays low.
- R6: A start strobe in the completion cycle begins a new word with no gap cycle. In that cycle the outputs still show the previous word's results.
- R7: A start strobe in the middle of a word drops that word and begins a new one. The dropped word produces no completion pulse.
- R8: A synchronous, active-high reset clears all syndromes to zero and holds `done_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Low in the cycle carrying the first symbol of a word |
| sym_in | input | 8 | Received symbol, highest power first |
| synd_o | output | 128 | Sixteen 8-bit syndromes, syndrome j in bits [8j+7:8j] |
| done_o | output | 1 | One-cycle pulse when all syndromes are final |
| err_o | output | 1 | High during the done pulse when any syndrome is nonzero |

## Verification
The assertions assume that a word in progress gets a fresh symbol every cycle. They also assume that reset is the only other event that can cut a word short, so the checker's own count of symbols since the last start strobe sets when the completion pulse is due. The stimulus always drives full words of 255 consecutive symbols. The only exceptions are the deliberate mid-word restart and reset cases, which the checker's model follows as well. Between words, the bench holds `start_n` high and drives random symbols, which exercises the hold behaviour without breaking those assumptions.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    localparam int SYM_W = 8;
    localparam logic [SYM_W:0] PRIM_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;

    // per-cycle control word from the sequencer to the accumulators
    typedef struct packed {
        logic acc_en;   // accumulator consumes sym this cycle
        logic load;     // first symbol: drop the stale accumulator value
        logic last;     // final symbol of the word
    } ctl_t;

    // shift-and-add field multiply, reduced by poly
    function automatic sym_t gf_mul(input sym_t a, input sym_t b,
                                    input logic [SYM_W:0] poly);
        sym_t p;
        sym_t x;
        p = '0;
        x = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) p = p ^ x;
            if (x[SYM_W-1]) x = (x << 1) ^ poly[SYM_W-1:0];
            else            x = x << 1;
        end
        return p;
    endfunction

    // alpha^e with alpha = 2
    function automatic sym_t gf_pow(input int e, input logic [SYM_W:0] poly);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2), poly);
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
    import rs_syn_pkg::*;
#(
    parameter int N_SYM = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    output ctl_t ctl,
    output logic done
);
    localparam int CNT_W = $clog2(N_SYM + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SYM - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             sof;

    always_comb begin
        sof        = !start_n;
        ctl.acc_en = sof || busy;
        ctl.load   = sof;
        if (sof) ctl.last = (N_SYM == 1);
        else     ctl.last = busy && (cnt == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= ctl.last;
            if (sof) begin
                busy <= (N_SYM > 1);
                cnt  <= CNT_W'(1);
            end else if (busy) begin
                cnt <= cnt + CNT_W'(1);
                if (ctl.last) busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
    import rs_syn_pkg::*;
#(
    parameter sym_t             ROOT = sym_t'(1),
    parameter logic [SYM_W:0]   POLY = PRIM_POLY
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_en,
    input  logic load,
    input  sym_t sym,
    output sym_t acc
);
    sym_t scaled;

    // constant multiplier: ROOT is fixed, so this folds into an XOR network
    always_comb begin
        if (load) scaled = '0;
        else      scaled = gf_mul(acc, ROOT, POLY);
    end

    always_ff @(posedge clk) begin
        if (rst)         acc <= '0;
        else if (acc_en) acc <= scaled ^ sym;
    end

endmodule

// File: rtl/rs_syn_flag.sv
module rs_syn_flag
    import rs_syn_pkg::*;
#(
    parameter int N_ROOT = 16
) (
    input  logic                     done,
    input  logic [SYM_W*N_ROOT-1:0]  synd,
    output logic                     err
);
    logic [N_ROOT-1:0] nz;

    for (genvar j = 0; j < N_ROOT; j++) begin : g_nz
        assign nz[j] = |synd[j*SYM_W +: SYM_W];
    end

    assign err = done && (|nz);

endmodule

// File: rtl/rs_syndrome.sv
module rs_syndrome
    import rs_syn_pkg::*;
#(
    parameter int             N_SYM      = 255,
    parameter int             N_ROOT     = 16,
    parameter int             FIRST_ROOT = 0,
    parameter logic [SYM_W:0] POLY       = PRIM_POLY
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_n,
    input  logic [SYM_W-1:0]        sym_in,
    output logic [SYM_W*N_ROOT-1:0] synd_o,
    output logic                    done_o,
    output logic                    err_o
);
    ctl_t ctl;
    sym_t synd_a [N_ROOT];

    rs_syn_ctrl #(.N_SYM(N_SYM)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .ctl     (ctl),
        .done    (done_o)
    );

    for (genvar j = 0; j < N_ROOT; j++) begin : g_root
        localparam sym_t ROOT_J = gf_pow(FIRST_ROOT + j, POLY);

        rs_syn_cell #(.ROOT(ROOT_J), .POLY(POLY)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .acc_en (ctl.acc_en),
            .load   (ctl.load),
            .sym    (sym_in),
            .acc    (synd_a[j])
        );

        assign synd_o[j*SYM_W +: SYM_W] = synd_a[j];
    end

    rs_syn_flag #(.N_ROOT(N_ROOT)) u_flag (
        .done (done_o),
        .synd (synd_o),
        .err  (err_o)
    );

endmodule

// File: rtl/rs_syndrome_chk.sv
module rs_syndrome_chk #(
    parameter int N_SYM  = 255,
    parameter int N_ROOT = 16,
    parameter int SYM_W  = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_n,
    input logic [SYM_W*N_ROOT-1:0] synd_o,
    input logic                    done_o,
    input logic                    err_o
);
    // independent frame model: counts symbols since the last start strobe
    logic m_busy;
    logic m_done;
    int   m_cnt;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_cnt  <= 0;
        end else begin
            m_done <= !start_n ? (N_SYM == 1) : (m_busy && m_cnt == N_SYM - 1);
            if (!start_n) begin
                m_busy <= (N_SYM > 1);
                m_cnt  <= 1;
            end else if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt == N_SYM - 1) m_busy <= 1'b0;
            end
        end
    end

    // R3
    done_timing_chk: assert property (@(posedge clk) disable iff (rst)
        done_o == m_done);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    err_gate_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!m_busy && start_n) |=> $stable(synd_o));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (m_busy && !start_n) |=> !done_o);

    // R8
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_state_chk: assert (synd_o == '0 && !done_o && !err_o);
        end
    end

endmodule

bind rs_syndrome rs_syndrome_chk #(
    .N_SYM  (N_SYM),
    .N_ROOT (N_ROOT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .synd_o  (synd_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/sim_rs_syndrome.sv
module sim_rs_syndrome;
    localparam int CLK_PERIOD = 10;
    localparam int N_SYM  = 255;
    localparam int N_ROOT = 16;
    localparam int N_MSG  = N_SYM - N_ROOT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1;
    logic [7:0] sym_in = 8'h00;
    logic [8*N_ROOT-1:0] synd_o;
    logic done_o;
    logic err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] word [N_SYM];
    logic [7:0] gpoly [N_ROOT+1];
    logic [8*N_ROOT-1:0] exp_cur, exp_prev;
    bit exp_err, exp_prev_err;

    rs_syndrome u0 (
        .clk(clk), .rst(rst), .start_n(start_n), .sym_in(sym_in),
        .synd_o(synd_o), .done_o(done_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p ^= (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p ^= (16'h011D << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] fpow(int e);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < (e % 255); i++) r = fmul(r, 8'h02);
        return r;
    endfunction

    task automatic check(bit ok, string req, string what,
                         logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic make_gen();
        for (int j = 0; j <= N_ROOT; j++) gpoly[j] = 8'h00;
        gpoly[0] = 8'h01;
        for (int i = 0; i < N_ROOT; i++) begin
            logic [7:0] r = fpow(i);
            for (int j = N_ROOT; j >= 1; j--) gpoly[j] = gpoly[j-1] ^ fmul(gpoly[j], r);
            gpoly[0] = fmul(gpoly[0], r);
        end
    endtask

    task automatic random_word();
        for (int k = 0; k < N_SYM; k++) word[k] = 8'($urandom);
    endtask

    task automatic encode_random();
        logic [7:0] rg [N_ROOT];
        for (int j = 0; j < N_ROOT; j++) rg[j] = 8'h00;
        for (int k = 0; k < N_MSG; k++) begin
            logic [7:0] fb;
            word[k] = 8'($urandom);
            fb = word[k] ^ rg[N_ROOT-1];
            for (int j = N_ROOT-1; j >= 1; j--) rg[j] = rg[j-1] ^ fmul(fb, gpoly[j]);
            rg[0] = fmul(fb, gpoly[0]);
        end
        for (int j = 0; j < N_ROOT; j++) word[N_MSG + j] = rg[N_ROOT-1-j];
    endtask

    task automatic ref_synd();
        exp_cur = '0;
        for (int j = 0; j < N_ROOT; j++) begin
            logic [7:0] acc = 8'h00;
            logic [7:0] r = fpow(j);
            for (int k = 0; k < N_SYM; k++) acc = fmul(acc, r) ^ word[k];
            exp_cur[8*j +: 8] = acc;
        end
        exp_err = (exp_cur != '0);
    endtask

    task automatic run_frame(bit chk_prev, string req);
        int glitch = 0;
        for (int k = 0; k < N_SYM; k++) begin
            @(negedge clk);
            if (k == 0 && chk_prev) begin
                check(done_o === 1'b1, "R6", "done in back-to-back cycle", 128'(done_o), 128'(1));
                check(synd_o === exp_prev, "R6", "previous syndromes shown", synd_o, exp_prev);
                check(err_o === exp_prev_err, "R6", "previous err shown", 128'(err_o), 128'(exp_prev_err));
            end else if (done_o !== 1'b0) begin
                glitch++;
            end
            start_n = (k != 0);
            sym_in = word[k];
        end
        check(glitch == 0, "R3", {"no early done ", req}, 128'(glitch), 128'(0));
    endtask

    task automatic check_result(string req);
        @(negedge clk);
        check(done_o === 1'b1, "R3", {"done after last symbol ", req}, 128'(done_o), 128'(1));
        check(synd_o === exp_cur, req, "syndromes", synd_o, exp_cur);
        check(err_o === exp_err, "R4", {"error flag ", req}, 128'(err_o), 128'(exp_err));
        start_n = 1'b1;
        sym_in = 8'($urandom);
    endtask

    task automatic idle_hold(int cycles);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done_o !== 1'b0 || err_o !== 1'b0) bad++;
            start_n = 1'b1;
            sym_in = 8'($urandom);
        end
        @(negedge clk);
        check(bad == 0, "R5", "done quiet while idle", 128'(bad), 128'(0));
        check(synd_o === exp_cur, "R5", "syndromes held while idle", synd_o, exp_cur);
    endtask

    initial begin
        logic [8*N_ROOT-1:0] e_flat;
        int dummy;
        dummy = $urandom(32'h1357);
        make_gen();

        // R8: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(synd_o === '0 && done_o === 1'b0 && err_o === 1'b0, "R8", "reset state",
              synd_o, '0);

        // R1: ordering, first symbol is highest power
        for (int k = 0; k < N_SYM; k++) word[k] = 8'h00;
        word[0] = 8'h01;
        e_flat = '0;
        for (int j = 0; j < N_ROOT; j++) e_flat[8*j +: 8] = fpow(254 * j);
        exp_cur = e_flat; exp_err = 1;
        run_frame(0, "R1");
        check_result("R1");
        // R1: last symbol is constant term
        for (int k = 0; k < N_SYM; k++) word[k] = 8'h00;
        word[N_SYM-1] = 8'hA7;
        for (int j = 0; j < N_ROOT; j++) e_flat[8*j +: 8] = 8'hA7;
        exp_cur = e_flat; exp_err = 1;
        run_frame(0, "R1");
        check_result("R1");

        // R4: valid codeword gives zero syndromes
        encode_random();
        exp_cur = '0; exp_err = 0;
        run_frame(0, "R4");
        check_result("R4");

        // R4/R2: single symbol error, syndrome j = e * alpha^(j*deg)
        begin
            int p = 77;
            logic [7:0] e = 8'h5C;
            word[p] = word[p] ^ e;
            for (int j = 0; j < N_ROOT; j++)
                e_flat[8*j +: 8] = fmul(e, fpow(j * (N_SYM - 1 - p)));
            exp_cur = e_flat; exp_err = 1;
            run_frame(0, "R2");
            check_result("R2");
        end

        // R4: all-zero word
        for (int k = 0; k < N_SYM; k++) word[k] = 8'h00;
        ref_synd();
        run_frame(0, "R4");
        check_result("R4");

        // R2: random words
        for (int t = 0; t < 4; t++) begin
            random_word();
            ref_synd();
            run_frame(0, "R2");
            check_result("R2");
        end

        // R5: inputs ignored while idle
        idle_hold(20);

        // R6: back-to-back frames
        random_word();
        ref_synd();
        exp_prev = exp_cur; exp_prev_err = exp_err;
        run_frame(0, "R6");
        encode_random();
        exp_cur = '0; exp_err = 0;
        run_frame(1, "R6");
        check_result("R6");

        // R7: restart in mid-word
        begin
            int bad = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (done_o !== 1'b0) bad++;
                start_n = (k != 0);
                sym_in = 8'($urandom);
            end
            check(bad == 0, "R7", "no done during dropped word", 128'(bad), 128'(0));
            encode_random();
            exp_cur = '0; exp_err = 0;
            run_frame(0, "R7");
            check_result("R7");
        end

        // R8: reset clears nonzero syndromes
        random_word();
        ref_synd();
        run_frame(0, "R8");
        check_result("R2");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(synd_o === '0 && done_o === 1'b0 && err_o === 1'b0, "R8", "reset clears",
              synd_o, '0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule